// File: doc/BRIEF.md
# Key-Guarded Routine Loader

This block guards the command that loads an on-chip routine into working RAM. Software first writes an unlock value into a key register. It then picks exactly one routine in a selection register, sets a destination address and raises a start bit. The start bit is accepted only when two conditions hold: the key register holds the unlock value, and the write comes from the trusted on-chip RAM region.

Once the start bit is set, the block waits a fixed number of idle cycles. It then runs a fixed sequence on its own:
1. Switch the bank to the routine store.
2. Check the selection and the destination.
3. Copy the routine one byte per cycle.
4. Drop the start bit.
5. Write a result byte at the destination address.
6. Switch the bank back to user space.
7. Pulse a return strobe.

Software learns the outcome only from the result byte in memory. The start bit is always back at 0 before the return strobe.

Top module: `dl_guard`

## Requirements
- R1: A write of 1 to bit 0 of the control register (address 1) sets the start bit only while the key register (address 0) holds 8'hA5. Otherwise the write is ignored and no sequence starts.
- R2: The start bit is set only when `reg_trusted` is high during the write. An untrusted write leaves it at 0 and starts nothing.
- R3: The selection register (address 2, bits [NR-1:0]) must have exactly one bit set. Otherwise no copy request is issued and bit 0 of the result byte is 1.
- R4: The bank switch (`bank_sel` rising) occurs in the fifth cycle after the clock edge that accepts the start write. The four cycles before it are idle: no bank switch, no copy, no result write.
- R5: The sequence order is fixed:
  - `bank_sel` rises;
  - the copy requests follow;
  - then the result write while `bank_sel` is high;
  - then `bank_sel` falls;
  - then `ret_pulse` lasts one cycle, with `bank_sel` low.
- R6: The start bit reads 0 (control register bit 0) from the result-write cycle onward. It is never 1 while `ret_pulse` is high.
- R7: The destination comes from the destination register (address 3):
  - the result byte is written at that address;
  - copy k (k = 0..LEN-1) moves routine-store byte sel_index*LEN+k to destination+1+k.
- R8: The destination is invalid when it is below RAM_BASE or above RAM_TOP-LEN. An invalid destination sets bit 1 of the result byte and suppresses all copies.
- R9: A successful sequence writes result byte 8'h00 and issues exactly LEN copy requests.
- R10: Writing any value other than 8'hA5 to the key register withdraws the unlock, so a later start write is ignored.
- R11: `busy` is high from the accepting edge through the `ret_pulse` cycle. Every register write while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 key, 1 control, 2 selection, 3 destination) |
| reg_wdata | input | 8 | Register write data |
| reg_trusted | input | 1 | Access originates from the trusted on-chip RAM region |
| reg_rdata | output | 8 | Read data of the addressed register |
| busy | output | 1 | Sequence in progress |
| bank_sel | output | 1 | 1 = routine store mapped, 0 = user space |
| cp_req | output | 1 | One-byte copy request |
| cp_src | output | AW | Copy source address in the routine store |
| cp_dst | output | AW | Copy destination address in RAM |
| res_we | output | 1 | Result byte write strobe |
| res_addr | output | AW | Result byte address |
| res_data | output | 8 | Result byte |
| ret_pulse | output | 1 | One-cycle return strobe |

## Verification
The assertions check these on every cycle:
- the start bit only ever rises after a trusted write while the key holds the unlock value;
- copies and the result write happen only with the routine bank mapped;
- at most one of copy, result write and return is active at a time;
- the bank switch comes exactly four idle cycles after busy rises;
- the start bit is already clear at return.

Only the bench scenarios can show the values themselves:
- the source and destination address of each copy;
- the value of the result byte for every selection pattern against valid and boundary destinations;
- that a withdrawn key or a write during busy leaves the registers unchanged.

// File: rtl/dl_guard_pkg.sv
package dl_guard_pkg;

    localparam logic [7:0] UNLOCK_KEY = 8'hA5;

    typedef enum logic [1:0] {
        RA_KEY  = 2'd0,
        RA_CTRL = 2'd1,
        RA_SEL  = 2'd2,
        RA_DEST = 2'd3
    } reg_addr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BANK,
        ST_CHECK,
        ST_COPY,
        ST_CLEAR,
        ST_RESULT,
        ST_UNBANK,
        ST_RET
    } seq_state_t;

    typedef struct packed {
        logic dst_err;
        logic sel_err;
    } chk_res_t;

    function automatic logic [7:0] result_byte(chk_res_t r);
        return {6'b0, r.dst_err, r.sel_err};
    endfunction

    function automatic logic any_err(chk_res_t r);
        return r.dst_err | r.sel_err;
    endfunction

endpackage

// File: rtl/dl_regs.sv
module dl_regs
    import dl_guard_pkg::*;
#(
    parameter int AW = 8,
    parameter int NR = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [7:0]    wdata,
    input  logic          trusted,
    input  logic          busy,
    input  logic          clr_start,
    output logic [7:0]    key_q,
    output logic          start_q,
    output logic [NR-1:0] sel_q,
    output logic [AW-1:0] dest_q,
    output logic          start_go,
    output logic [7:0]    rdata
);

    logic wr_ok;
    assign wr_ok    = wr && !busy;
    assign start_go = wr_ok && (reg_addr_t'(addr) == RA_CTRL) && wdata[0]
                      && (key_q == UNLOCK_KEY) && trusted;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q   <= '0;
            start_q <= 1'b0;
            sel_q   <= '0;
            dest_q  <= '0;
        end else begin
            if (clr_start) begin
                start_q <= 1'b0;
            end else if (start_go) begin
                start_q <= 1'b1;
            end
            if (wr_ok) begin
                case (reg_addr_t'(addr))
                    RA_KEY:  key_q  <= wdata;
                    RA_SEL:  sel_q  <= wdata[NR-1:0];
                    RA_DEST: dest_q <= wdata[AW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr_t'(addr))
            RA_KEY:  rdata = key_q;
            RA_CTRL: rdata = {7'b0, start_q};
            RA_SEL:  rdata = 8'(sel_q);
            default: rdata = 8'(dest_q);
        endcase
    end

endmodule

// File: rtl/dl_check.sv
module dl_check
    import dl_guard_pkg::*;
#(
    parameter int AW       = 8,
    parameter int NR       = 4,
    parameter int LEN      = 8,
    parameter int RAM_BASE = 64,
    parameter int RAM_TOP  = 255,
    localparam int IW      = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic [NR-1:0] sel,
    input  logic [AW-1:0] dest,
    output chk_res_t      res,
    output logic [IW-1:0] sel_idx
);

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NR; i++) begin
            if (sel[i]) sel_idx = IW'(i);
        end
    end

    always_comb begin
        res.sel_err = ($countones(sel) != 1);
        res.dst_err = (int'(dest) < RAM_BASE) || (int'(dest) > RAM_TOP - LEN);
    end

endmodule

// File: rtl/dl_seq.sv
module dl_seq
    import dl_guard_pkg::*;
#(
    parameter int AW       = 8,
    parameter int NR       = 4,
    parameter int LEN      = 8,
    parameter int WAIT_CYC = 4,
    localparam int IW      = (NR > 1) ? $clog2(NR) : 1,
    localparam int MAXC    = (LEN > WAIT_CYC) ? LEN : WAIT_CYC,
    localparam int CW      = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_go,
    input  chk_res_t      chk,
    input  logic [IW-1:0] sel_idx,
    input  logic [AW-1:0] dest,
    output logic          busy,
    output logic          bank_sel,
    output logic          cp_req,
    output logic [AW-1:0] cp_src,
    output logic [AW-1:0] cp_dst,
    output logic          clr_start,
    output logic          res_we,
    output logic [AW-1:0] res_addr,
    output logic [7:0]    res_data,
    output logic          ret_pulse
);

    seq_state_t state;
    logic [CW-1:0] cnt;
    chk_res_t      err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            err_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_go) begin
                    state <= ST_WAIT;
                    cnt   <= '0;
                end
                ST_WAIT: if (cnt == CW'(WAIT_CYC - 1)) state <= ST_BANK;
                         else cnt <= cnt + 1'b1;
                ST_BANK: state <= ST_CHECK;
                ST_CHECK: begin
                    err_q <= chk;
                    cnt   <= '0;
                    state <= any_err(chk) ? ST_CLEAR : ST_COPY;
                end
                ST_COPY: if (cnt == CW'(LEN - 1)) state <= ST_CLEAR;
                         else cnt <= cnt + 1'b1;
                ST_CLEAR:  state <= ST_RESULT;
                ST_RESULT: state <= ST_UNBANK;
                ST_UNBANK: state <= ST_RET;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign bank_sel  = (state == ST_BANK) || (state == ST_CHECK) || (state == ST_COPY)
                       || (state == ST_CLEAR) || (state == ST_RESULT);
    assign cp_req    = (state == ST_COPY);
    assign cp_src    = AW'(int'(sel_idx) * LEN + int'(cnt));
    assign cp_dst    = dest + AW'(1) + AW'(cnt);
    assign clr_start = (state == ST_CLEAR);
    assign res_we    = (state == ST_RESULT);
    assign res_addr  = dest;
    assign res_data  = result_byte(err_q);
    assign ret_pulse = (state == ST_RET);

endmodule

// File: rtl/dl_guard.sv
module dl_guard
    import dl_guard_pkg::*;
#(
    parameter int AW       = 8,
    parameter int NR       = 4,
    parameter int LEN      = 8,
    parameter int RAM_BASE = 64,
    parameter int RAM_TOP  = 255,
    parameter int WAIT_CYC = 4,
    localparam int IW      = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic          reg_trusted,
    output logic [7:0]    reg_rdata,
    output logic          busy,
    output logic          bank_sel,
    output logic          cp_req,
    output logic [AW-1:0] cp_src,
    output logic [AW-1:0] cp_dst,
    output logic          res_we,
    output logic [AW-1:0] res_addr,
    output logic [7:0]    res_data,
    output logic          ret_pulse
);

    logic [7:0]    key_q;
    logic          start_q;
    logic [NR-1:0] sel_q;
    logic [AW-1:0] dest_q;
    logic          start_go;
    logic          clr_start;
    chk_res_t      chk;
    logic [IW-1:0] sel_idx;

    dl_regs #(.AW(AW), .NR(NR)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .trusted(reg_trusted), .busy(busy), .clr_start(clr_start),
        .key_q(key_q), .start_q(start_q), .sel_q(sel_q), .dest_q(dest_q),
        .start_go(start_go), .rdata(reg_rdata)
    );

    dl_check #(.AW(AW), .NR(NR), .LEN(LEN), .RAM_BASE(RAM_BASE), .RAM_TOP(RAM_TOP)) u_check (
        .sel(sel_q), .dest(dest_q), .res(chk), .sel_idx(sel_idx)
    );

    dl_seq #(.AW(AW), .NR(NR), .LEN(LEN), .WAIT_CYC(WAIT_CYC)) u_seq (
        .clk(clk), .rst(rst), .start_go(start_go), .chk(chk), .sel_idx(sel_idx),
        .dest(dest_q), .busy(busy), .bank_sel(bank_sel), .cp_req(cp_req),
        .cp_src(cp_src), .cp_dst(cp_dst), .clr_start(clr_start), .res_we(res_we),
        .res_addr(res_addr), .res_data(res_data), .ret_pulse(ret_pulse)
    );

endmodule

// File: rtl/dl_guard_chk.sv
module dl_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       reg_trusted,
    input logic [7:0] key_q,
    input logic       start_q,
    input logic       busy,
    input logic       bank_sel,
    input logic       cp_req,
    input logic       res_we,
    input logic       ret_pulse
);

    // R1 R2 R10
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(start_q) |-> $past(reg_wr && reg_trusted && key_q == 8'hA5));

    // R4
    wait_four_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bank_sel) |-> ($past(busy, 4) && !$past(busy, 5)));

    // R5
    copy_banked_chk: assert property (@(posedge clk) disable iff (rst)
        (cp_req || res_we) |-> bank_sel);

    // R5
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cp_req, res_we, ret_pulse}));

    // R5
    ret_unbanked_chk: assert property (@(posedge clk) disable iff (rst)
        ret_pulse |-> (!bank_sel && busy));

    // R6
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ret_pulse |-> !start_q);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !ret_pulse) |=> busy);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(bank_sel || cp_req || res_we));

endmodule

bind dl_guard dl_guard_chk i_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_trusted(reg_trusted),
    .key_q(key_q), .start_q(start_q), .busy(busy), .bank_sel(bank_sel),
    .cp_req(cp_req), .res_we(res_we), .ret_pulse(ret_pulse)
);

// File: tb/test_dl_guard.sv
module test_dl_guard;

    localparam int AW = 8, NR = 4, LEN = 8, RAM_BASE = 64, RAM_TOP = 255;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    reg_wdata = 8'd0;
    logic          reg_trusted = 1'b0;
    logic [7:0]    reg_rdata;
    logic          busy, bank_sel, cp_req, res_we, ret_pulse;
    logic [AW-1:0] cp_src, cp_dst, res_addr;
    logic [7:0]    res_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dl_guard i_dl_guard (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_trusted(reg_trusted), .reg_rdata(reg_rdata),
        .busy(busy), .bank_sel(bank_sel), .cp_req(cp_req), .cp_src(cp_src),
        .cp_dst(cp_dst), .res_we(res_we), .res_addr(res_addr), .res_data(res_data),
        .ret_pulse(ret_pulse)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d, input logic tr);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_trusted = tr;
        @(negedge clk);
        reg_wr = 1'b0; reg_trusted = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Expect nothing to start over the next cycles.
    task automatic expect_idle(input string tag);
        logic [7:0] v;
        int act;
        act = 0;
        for (int n = 0; n < 12; n++) begin
            if (busy || bank_sel || cp_req || res_we || ret_pulse) act++;
            @(negedge clk);
        end
        chk(act == 0, tag, act, 0);
        rreg(2'd1, v);
        chk(v[0] == 1'b0, tag, v, 0);
    endtask

    task automatic run(input logic [3:0] sel, input logic [7:0] dest, input logic poke);
        int pop, idx, bank_at, ncp, nres, ret_at, unbank_at, res_at, n;
        logic sel_err, dst_err, done;
        logic [7:0] exp_res, v;
        pop = 0; idx = 0;
        for (int i = 0; i < NR; i++) if (sel[i]) begin pop++; idx = i; end
        sel_err = (pop != 1);
        dst_err = (int'(dest) < RAM_BASE) || (int'(dest) > RAM_TOP - LEN);
        exp_res = {6'b0, dst_err, sel_err};
        wreg(2'd0, 8'hA5, 1'b1);
        wreg(2'd2, 8'(sel), 1'b1);
        wreg(2'd3, dest, 1'b1);
        wreg(2'd1, 8'h01, 1'b1);
        // now mid-cycle 1 after accepting edge
        bank_at = 0; ncp = 0; nres = 0; ret_at = 0; unbank_at = 0; res_at = 0;
        done = 1'b0;
        for (n = 1; n < 40 && !done; n++) begin
            chk(busy, "R11 busy", busy, 1);
            if (bank_sel && bank_at == 0) bank_at = n;
            if (!bank_sel && bank_at != 0 && unbank_at == 0) unbank_at = n;
            if (cp_req) begin
                chk(int'(cp_src) == idx * LEN + ncp, "R7 src", cp_src, idx * LEN + ncp);
                chk(cp_dst == dest + 8'(1 + ncp), "R7 dst", cp_dst, dest + 8'(1 + ncp));
                chk(res_at == 0, "R5 copy before result", res_at, 0);
                ncp++;
            end
            if (res_we) begin
                nres++; res_at = n;
                chk(res_addr == dest, "R7 result addr", res_addr, dest);
                chk(res_data == exp_res, (exp_res == 0) ? "R9 result" :
                    (sel_err ? "R3 result" : "R8 result"), res_data, exp_res);
                rreg(2'd1, v);
                chk(v[0] == 1'b0, "R6 start cleared", v, 0);
            end
            if (ret_pulse) begin
                ret_at = n; done = 1'b1;
                rreg(2'd1, v);
                chk(v[0] == 1'b0, "R6 start at return", v, 0);
            end
            if (poke && n == 2) begin
                reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h10; reg_trusted = 1'b1;
            end
            if (poke && n == 3) begin
                reg_wr = 1'b0; reg_trusted = 1'b0;
            end
            @(negedge clk);
        end
        chk(bank_at == 5, "R4 bank timing", bank_at, 5);
        chk(ncp == ((exp_res == 0) ? LEN : 0), "R3 R8 R9 copy count", ncp, (exp_res == 0) ? LEN : 0);
        chk(nres == 1, "R5 result count", nres, 1);
        chk(unbank_at == res_at + 1 && ret_at == unbank_at + 1, "R5 order", ret_at, res_at + 2);
        chk(!busy, "R11 busy end", busy, 0);
        if (poke) begin
            rreg(2'd3, v);
            chk(v == dest, "R11 write ignored", v, dest);
        end
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 150000) begin @(posedge clk); wd++; end
        errors++; checks++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] dests [8];
        dests = '{8'h00, 8'h3F, 8'h40, 8'h41, 8'h80, 8'hF7, 8'hF8, 8'hFF};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !bank_sel && !cp_req && !res_we && !ret_pulse, "R11 reset outputs", busy, 0);
        rreg(2'd1, v); chk(v == 8'h00, "R6 reset start", v, 0);
        rreg(2'd0, v); chk(v == 8'h00, "R1 reset key", v, 0);

        for (int s = 0; s < 16; s++)
            for (int d = 0; d < 8; d++)
                run(4'(s), dests[d], 1'b0);

        run(4'b0100, 8'h90, 1'b1);

        // R1 wrong key
        wreg(2'd0, 8'h5A, 1'b1);
        wreg(2'd2, 8'h01, 1'b1);
        wreg(2'd3, 8'h80, 1'b1);
        wreg(2'd1, 8'h01, 1'b1);
        expect_idle("R1 wrong key");

        // R2 untrusted
        wreg(2'd0, 8'hA5, 1'b1);
        wreg(2'd1, 8'h01, 1'b0);
        expect_idle("R2 untrusted");

        // R10 key withdrawn
        wreg(2'd0, 8'hA5, 1'b1);
        wreg(2'd0, 8'h00, 1'b1);
        wreg(2'd1, 8'h01, 1'b1);
        expect_idle("R10 key withdrawn");

        // R1 key restored, accepted again
        run(4'b0010, 8'h40, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule